// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter Core

This block is a direct-form FIR filter built around a fixed row of sixteen multiply-accumulate cells. Each cell can be reused several times inside one sample period, so the same hardware gives a short filter at the full clock rate or a longer filter at a lower rate. A 16-bit control word turns the filter on, sets the reuse factor (1, 2, 4 or 8 clocks per input sample), and can enable a decimate-by-two mode. In that mode one result is produced for every two input samples and the tap count doubles again.

Samples arrive on a 16-bit port. The block takes a sample in every cycle where `in_take` is high. Coefficients are written one at a time into an internal store. Each stored coefficient keeps only the upper 12 bits of the written 16-bit value. Each result is the 32-bit wrapped sum of all tap products plus a 32-bit partial sum from a cascade port. The block also sends out a delayed copy of its sample line, so a further device can carry the filter on. The output bus is gated by an output enable that is registered one clock before it acts.

Top module: `mcfir_core`

## Requirements
- R1: After synchronous reset the control word is 0x8000 (filter on, reuse 1, no decimation), every stored coefficient and every held sample is zero, `in_take` is 1, and `res_vld`, `dout` and `casc_dout` are 0.
- R2: Control bits [14:13] hold a code c that gives reuse R = 2^c. Counting from the first clock edge after a control write, a sample is taken at every R-th edge, and `in_take` is high in exactly the cycles that precede those edges.
- R3: Control bit 12 turns on decimation. The result period is then L = 2R clocks and the filter has 16L taps. Without bit 12, L = R and there are 16R taps. Bit 12 is ignored when c = 3.
- R4: Each result is the sum over k < 16L of x[n-k]·h[k] plus `casc_in`, wrapped to 32 bits. Here x[n] is the newest sample at the start of the window.
- R5: The window starts at the edge that takes x[n] when the phase is 0. The result is registered L+1 edges later, using `casc_in` as seen at that edge. `res_vld` is high for exactly that one cycle.
- R6: After the sample x[n] has been taken, `casc_dout` shows x[n-16L+1], or zero while the line is still filling. It changes only at an edge where a sample is taken or the control word is written.
- R7: `dout` shows the last result when `oe` was high at the previous edge, and zero otherwise.
- R8: A write to coefficient address k sets the weight h[k] for the k-th newest sample. The weight is the written 16-bit value shifted right arithmetically by 4 bits.
- R9: When control bit 15 is 0 the filter is idle: `in_take` and `res_vld` stay 0.
- R10: A control write clears the sample line, the pipeline and the held result, and restarts the phase at 0. The next edge takes a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word (bit 15 on, [14:13] reuse, 12 decimate) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient address (tap index) |
| coef_wdata | input | 16 | Coefficient value, two's complement |
| din | input | 16 | Input sample, two's complement |
| in_take | output | 1 | The next edge takes `din` |
| oe | input | 1 | Output enable, registered |
| casc_in | input | 32 | Partial sum from a cascaded device |
| dout | output | 32 | Filter result, zero when disabled |
| res_vld | output | 1 | New result present on the result register |
| casc_dout | output | 16 | Delayed sample for a cascaded device |

## Verification
The checker assertions watch timing rules on every cycle:
- the spacing of `in_take` and `res_vld` for the current reuse and decimation setting;
- the idle state when bit 15 is clear;
- the hold of `casc_dout` between sample edges;
- the one-clock lag of the output enable;
- the restart after a control write.

The numbers themselves can only be shown by the bench's scenarios. These are the convolution value, the truncated weights, the cascade sum, the tap count per mode and the exact L+1 latency. The bench compares them every clock against a behavioural model, over every reuse code, with and without decimation, for an impulse coefficient set, and for idle control words.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;
   localparam int LOGW       = 3;
   localparam int CTRL_W     = 16;
   localparam int BIT_ON     = 15;
   localparam int BIT_DEC    = 12;
   localparam int REUSE_LSB  = 13;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h8000;

   typedef struct packed {
      logic            active;
      logic [LOGW-1:0] r_log;   // log2 of clocks per input sample
      logic [LOGW-1:0] l_log;   // log2 of clocks per result window
   } mode_t;

   function automatic mode_t decode_ctrl(input logic [CTRL_W-1:0] w, input int unsigned max_log);
      mode_t       m;
      int unsigned r;
      r = int'(unsigned'(w[REUSE_LSB+1:REUSE_LSB]));
      if (r > max_log) r = max_log;
      m.active = w[BIT_ON];
      m.r_log  = LOGW'(r);
      m.l_log  = (w[BIT_DEC] && (r < max_log)) ? LOGW'(r + 1) : LOGW'(r);
      return m;
   endfunction
endpackage

// File: rtl/mcfir_ctrl.sv
module mcfir_ctrl
   import mcfir_pkg::*;
#(
   parameter int MAXLOG = 3,
   parameter int PHW    = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ctrl_we,
   input  logic [CTRL_W-1:0]   ctrl_wdata,
   output mode_t               mode,
   output logic [PHW-1:0]      ph,
   output logic [PHW-1:0]      ph_last,
   output logic                take,
   output logic                win,
   output logic [PHW-1:0]      sp,
   output logic                sp_v
);
   logic [PHW-1:0] r_mask;

   always_comb begin
      ph_last = PHW'((1 << mode.l_log) - 1);
      r_mask  = PHW'((1 << mode.r_log) - 1);
      take    = mode.active && ((ph & r_mask) == '0);
      win     = take && (ph == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= decode_ctrl(CTRL_RESET, MAXLOG);
         ph   <= '0;
         sp   <= '0;
         sp_v <= 1'b0;
      end else if (ctrl_we) begin
         mode <= decode_ctrl(ctrl_wdata, MAXLOG);
         ph   <= '0;
         sp   <= '0;
         sp_v <= 1'b0;
      end else begin
         if (mode.active) ph <= (ph == ph_last) ? '0 : ph + 1'b1;
         sp   <= ph;
         sp_v <= mode.active;
      end
   end
endmodule

// File: rtl/mcfir_coef_bank.sv
module mcfir_coef_bank #(
   parameter int CIW   = 16,
   parameter int CW    = 12,
   parameter int NCELL = 16,
   parameter int TAPS  = 128,
   parameter int PHW   = 3,
   localparam int ADW  = $clog2(TAPS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  we,
   input  logic [ADW-1:0]        addr,
   input  logic [CIW-1:0]        wdata,
   input  logic [PHW-1:0]        sp,
   output logic signed [CW-1:0]  cell_c [NCELL]
);
   logic signed [CW-1:0] mem [TAPS];
   logic signed [CW-1:0] stored;

   generate
      if (CW < CIW) begin : g_trunc
         always_comb stored = signed'(wdata[CIW-1 -: CW]);
      end else begin : g_extend
         always_comb stored = CW'(signed'(wdata));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TAPS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= stored;
      end
   end

   always_comb begin
      for (int c = 0; c < NCELL; c++)
         cell_c[c] = mem[ADW'(int'(sp) * NCELL + c)];
   end
endmodule

// File: rtl/mcfir_tapline.sv
module mcfir_tapline
   import mcfir_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NCELL = 16,
   parameter int TAPS  = 128,
   parameter int PHW   = 3,
   localparam int ADW  = $clog2(TAPS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clear,
   input  logic                  take,
   input  logic                  win,
   input  logic signed [DW-1:0]  din,
   input  logic [PHW-1:0]        sp,
   input  logic [LOGW-1:0]       l_log,
   output logic signed [DW-1:0]  cell_x [NCELL],
   output logic [DW-1:0]         casc_out
);
   logic signed [DW-1:0] hist [TAPS];
   logic signed [DW-1:0] snap [TAPS];
   logic [ADW-1:0]       last_idx;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         for (int i = 0; i < TAPS; i++) begin
            hist[i] <= '0;
            snap[i] <= '0;
         end
      end else if (take) begin
         hist[0] <= din;
         for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
         if (win) begin
            snap[0] <= din;
            for (int i = 1; i < TAPS; i++) snap[i] <= hist[i-1];
         end
      end
   end

   always_comb begin
      last_idx = ADW'((NCELL << l_log) - 1);
      casc_out = hist[last_idx];
      for (int c = 0; c < NCELL; c++)
         cell_x[c] = snap[ADW'(int'(sp) * NCELL + c)];
   end
endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac #(
   parameter int NCELL = 16,
   parameter int DW    = 16,
   parameter int CW    = 12,
   parameter int AW    = 32,
   parameter int PHW   = 3,
   localparam int PW   = DW + CW
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clear,
   input  logic [PHW-1:0]        sp,
   input  logic                  sp_v,
   input  logic [PHW-1:0]        ph_last,
   input  logic signed [DW-1:0]  cell_x [NCELL],
   input  logic signed [CW-1:0]  cell_c [NCELL],
   input  logic [AW-1:0]         casc_in,
   output logic [AW-1:0]         res,
   output logic                  vld
);
   logic signed [PW-1:0] prod [NCELL];
   logic [PHW-1:0]       pp;
   logic                 pp_v;
   logic [AW-1:0]        sum;
   logic [AW-1:0]        acc;
   logic [AW-1:0]        base;

   generate
      for (genvar c = 0; c < NCELL; c++) begin : g_cell
         always_ff @(posedge clk) begin
            if (rst) prod[c] <= '0;
            else     prod[c] <= cell_x[c] * cell_c[c];
         end
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int c = 0; c < NCELL; c++)
         sum = sum + AW'(prod[c]);
      base = (pp == '0) ? '0 : acc;
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         pp   <= '0;
         pp_v <= 1'b0;
         acc  <= '0;
         res  <= '0;
         vld  <= 1'b0;
      end else begin
         pp   <= sp;
         pp_v <= sp_v;
         vld  <= 1'b0;
         if (pp_v) begin
            acc <= base + sum;
            if (pp == ph_last) begin
               res <= base + sum + casc_in;
               vld <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mcfir_core.sv
module mcfir_core
   import mcfir_pkg::*;
#(
   parameter int NCELL    = 16,
   parameter int MAXREUSE = 8,
   parameter int DW       = 16,
   parameter int CIW      = 16,
   parameter int CW       = 12,
   parameter int AW       = 32,
   localparam int TAPS    = NCELL * MAXREUSE,
   localparam int ADW     = $clog2(TAPS),
   localparam int MAXLOG  = $clog2(MAXREUSE),
   localparam int PHW     = (MAXLOG > 0) ? MAXLOG : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctrl_we,
   input  logic [15:0]       ctrl_wdata,
   input  logic              coef_we,
   input  logic [ADW-1:0]    coef_addr,
   input  logic [CIW-1:0]    coef_wdata,
   input  logic [DW-1:0]     din,
   output logic              in_take,
   input  logic              oe,
   input  logic [AW-1:0]     casc_in,
   output logic [AW-1:0]     dout,
   output logic              res_vld,
   output logic [DW-1:0]     casc_dout
);
   generate
      if ((MAXREUSE & (MAXREUSE - 1)) != 0 || MAXREUSE > 8)
         $error("MAXREUSE must be a power of two no larger than 8");
      if ((NCELL & (NCELL - 1)) != 0)
         $error("NCELL must be a power of two");
      if (AW < DW + CW)
         $error("AW must hold a full product");
      if (CW > CIW)
         $error("CW must not exceed CIW");
   endgenerate

   mode_t                mode;
   logic [PHW-1:0]       ph, ph_last, sp;
   logic                 win, sp_v, oe_r;
   logic signed [DW-1:0] cell_x [NCELL];
   logic signed [CW-1:0] cell_c [NCELL];
   logic [AW-1:0]        res;

   mcfir_ctrl #(.MAXLOG(MAXLOG), .PHW(PHW)) u_ctrl (
      .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .mode(mode), .ph(ph), .ph_last(ph_last), .take(in_take), .win(win),
      .sp(sp), .sp_v(sp_v));

   mcfir_coef_bank #(.CIW(CIW), .CW(CW), .NCELL(NCELL), .TAPS(TAPS), .PHW(PHW)) u_coef (
      .clk(clk), .rst(rst), .we(coef_we), .addr(coef_addr), .wdata(coef_wdata),
      .sp(sp), .cell_c(cell_c));

   mcfir_tapline #(.DW(DW), .NCELL(NCELL), .TAPS(TAPS), .PHW(PHW)) u_line (
      .clk(clk), .rst(rst), .clear(ctrl_we), .take(in_take), .win(win),
      .din(signed'(din)), .sp(sp), .l_log(mode.l_log), .cell_x(cell_x),
      .casc_out(casc_dout));

   mcfir_mac #(.NCELL(NCELL), .DW(DW), .CW(CW), .AW(AW), .PHW(PHW)) u_mac (
      .clk(clk), .rst(rst), .clear(ctrl_we), .sp(sp), .sp_v(sp_v),
      .ph_last(ph_last), .cell_x(cell_x), .cell_c(cell_c), .casc_in(casc_in),
      .res(res), .vld(res_vld));

   always_ff @(posedge clk) begin
      if (rst) oe_r <= 1'b0;
      else     oe_r <= oe;
   end

   assign dout = oe_r ? res : '0;
endmodule

// File: rtl/mcfir_core_chk.sv
module mcfir_core_chk
   import mcfir_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          ctrl_we,
   input logic          oe,
   input logic          in_take,
   input logic          res_vld,
   input logic [AW-1:0] dout,
   input logic [DW-1:0] casc_dout,
   input mode_t         mode
);
   AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (rst) (in_take && mode.r_log != '0 && !ctrl_we) |=> !in_take); // R2
   AST_VLD_SPACING: assert property (@(posedge clk) disable iff (rst) (res_vld && mode.l_log != '0) |=> !res_vld); // R3
   AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst) (!$past(in_take) && !$past(ctrl_we)) |-> $stable(casc_dout)); // R6
   AST_OE_LAG: assert property (@(posedge clk) disable iff (rst) !$past(oe) |-> (dout == '0)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !mode.active |-> (!in_take && !res_vld)); // R9
   AST_RESTART: assert property (@(posedge clk) disable iff (rst) ctrl_we |=> (!res_vld && (in_take == mode.active))); // R10
endmodule

bind mcfir_core mcfir_core_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .oe(oe), .in_take(in_take),
   .res_vld(res_vld), .dout(dout), .casc_dout(casc_dout), .mode(mode));

// File: tb/mcfir_core_bench.sv
module mcfir_core_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ctrl_we = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic        coef_we = 1'b0;
   logic [6:0]  coef_addr = '0;
   logic [15:0] coef_wdata = '0;
   logic [15:0] din = '0;
   logic        oe = 1'b0;
   logic [31:0] casc_in = '0;
   logic        in_take, res_vld;
   logic [31:0] dout;
   logic [15:0] casc_dout;

   int checks = 0;
   int errors = 0;
   bit chk_en = 1'b0;
   bit done   = 1'b0;
   string scen = "R1 reset";

   always #4 clk = ~clk;

   mcfir_core u_mcfir_core (
      .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
      .din(din), .in_take(in_take), .oe(oe), .casc_in(casc_in),
      .dout(dout), .res_vld(res_vld), .casc_dout(casc_dout));

   // behavioural reference model
   int          m_cnt, m_r, m_l, m_t;
   bit          m_act;
   int          mh [128];
   int          mc [128];
   int          due_q [$];
   logic [31:0] val_q [$];
   logic [31:0] e_res;
   bit          e_vld, e_oe;

   function automatic void m_mode(input logic [15:0] w);
      int rl, ll;
      rl    = int'(w[14:13]);
      ll    = (w[12] && rl < 3) ? rl + 1 : rl;
      m_act = w[15];
      m_r   = 1 << rl;
      m_l   = 1 << ll;
      m_t   = 16 * m_l;
   endfunction

   function automatic void m_flush();
      for (int i = 0; i < 128; i++) mh[i] = 0;
      due_q.delete();
      val_q.delete();
      m_cnt = 0;
      e_res = '0;
      e_vld = 1'b0;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_mode(16'h8000);
         m_flush();
         for (int i = 0; i < 128; i++) mc[i] = 0;
         e_oe = 1'b0;
      end else begin
         e_oe = oe;
         if (coef_we) mc[coef_addr] = int'($signed(coef_wdata) >>> 4);
         if (ctrl_we) begin
            m_mode(ctrl_wdata);
            m_flush();
         end else begin
            e_vld = 1'b0;
            if (due_q.size() > 0 && due_q[0] == m_cnt) begin
               e_res = val_q[0] + casc_in;
               e_vld = 1'b1;
               void'(due_q.pop_front());
               void'(val_q.pop_front());
            end
            if (m_act) begin
               if (m_cnt % m_r == 0) begin
                  for (int i = 127; i > 0; i--) mh[i] = mh[i-1];
                  mh[0] = int'($signed(din));
               end
               if (m_cnt % m_l == 0) begin
                  logic [31:0] s;
                  s = '0;
                  for (int k = 0; k < m_t; k++) s = s + 32'(mh[k] * mc[k]);
                  due_q.push_back(m_cnt + m_l + 1);
                  val_q.push_back(s);
               end
               m_cnt++;
            end
         end
      end
   end

   task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL [%s] %s: got %h expected %h at %0t", scen, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en && !rst) begin
         check("R2 in_take", 32'(in_take), 32'(m_act && (m_cnt % m_r == 0)));
         check("R5 res_vld", 32'(res_vld), 32'(e_vld));
         check("R4/R7 dout", dout, e_oe ? e_res : 32'h0);
         check("R6 casc_dout", 32'(casc_dout), 32'(mh[m_t-1][15:0]));
      end
   end

   task automatic run(input int n);
      repeat (n) begin
         @(posedge clk); #1;
         din     = 16'($urandom);
         casc_in = $urandom;
         oe      = ($urandom % 4) != 0;
      end
   endtask

   task automatic ctrl_write(input logic [15:0] w);
      @(posedge clk); #1;
      ctrl_we = 1'b1; ctrl_wdata = w;
      @(posedge clk); #1;
      ctrl_we = 1'b0;
      chk_en  = 1'b1;
   endtask

   task automatic load_coefs(input bit impulse);
      chk_en = 1'b0;
      for (int a = 0; a < 128; a++) begin
         @(posedge clk); #1;
         coef_we   = 1'b1;
         coef_addr = 7'(a);
         if (impulse) coef_wdata = (a == 37) ? 16'h1230 : (a == 0) ? 16'hFFFF : 16'h0;
         else         coef_wdata = 16'($urandom);
      end
      @(posedge clk); #1;
      coef_we = 1'b0;
   endtask

   task automatic mode_run(input string s, input logic [15:0] w);
      int r, l;
      scen = s;
      ctrl_write(w);
      r = 1 << int'(w[14:13]);
      l = (w[12] && w[14:13] != 2'b11) ? 2 * r : r;
      run(16 * l * r + 3 * l + 24);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R1 in_take", 32'(in_take), 32'h1);
      check("R1 res_vld", 32'(res_vld), 32'h0);
      check("R1 dout", dout, 32'h0);
      check("R1 casc_dout", 32'(casc_dout), 32'h0);
      chk_en = 1'b1;
      run(40);
      load_coefs(1'b0);
      mode_run("R2 reuse1", 16'h8000);
      mode_run("R2 reuse2", 16'hA000);
      mode_run("R2 reuse4", 16'hC000);
      mode_run("R2 reuse8", 16'hE000);
      mode_run("R3 dec reuse1", 16'h9000);
      mode_run("R3 dec reuse2", 16'hB000);
      mode_run("R3 dec reuse4", 16'hD000);
      mode_run("R3 dec ignored", 16'hF000);
      mode_run("R9 idle", 16'h0000);
      mode_run("R9 idle bits", 16'h7000);
      scen = "R10 restart";
      ctrl_write(16'hA000);
      run(37);
      ctrl_write(16'hA000);
      run(90);
      load_coefs(1'b1);
      mode_run("R8 impulse", 16'hC000);
      mode_run("R8 impulse dec", 16'h9000);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule